// File: doc/BRIEF.md
# Fibonacci Term Generator Datapath

This block produces Fibonacci numbers from a small datapath that an outside controller steps. The datapath has three loadable registers: an "older term" register, a "newer term" register and a "sum" register. An adder adds the older and newer terms. A source multiplexer picks what the two term registers load next: either fixed seed constants, or the feedback path that moves every term one place along the sequence.

The block does not run by itself. Each register has its own load strobe, and one select line picks seed or feedback. A controller starts the sequence by loading the seeds. It then alternates two steps: capture the sum, then shift the terms along. After each sum capture the output shows the next Fibonacci number. All arithmetic is WIDTH bits wide and wraps silently.

Top module: `fib_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all three registers to 0 at the clock edge, whatever the load strobes are. `term_out` reads 0 in the cycle after a reset edge.
- R2: When `sel_run` is 0 and `ld_old` is 1, the older-term register loads the seed SEED_OLD (default 0) at the clock edge.
- R3: When `sel_run` is 0 and `ld_new` is 1, the newer-term register loads the seed SEED_NEW (default 1) at the clock edge.
- R4: When `sel_run` is 1, `ld_old` loads the older-term register from the newer-term register, and `ld_new` loads the newer-term register from the sum register. Both loads use the values held before that edge.
- R5: When `ld_sum` is 1, the sum register loads (older + newer) mod 2^WIDTH at the clock edge, whatever `sel_run` is.
- R6: A register whose load strobe is 0 keeps its value across the edge. Each strobe acts only on its own register.
- R7: `term_out` is the content of the sum register, driven straight from a flop with no combinational path from any input.
- R8: After a seed load, alternating sum captures and forward shifts make `term_out` show F(2), F(3), … in turn, where F(0)=0 and F(1)=1. F(24)=46368 is the last term that fits in 16 bits, and later terms wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_old | input | 1 | Load strobe of the older-term register |
| ld_new | input | 1 | Load strobe of the newer-term register |
| ld_sum | input | 1 | Load strobe of the sum register |
| sel_run | input | 1 | 0 selects seed constants, 1 selects feedback |
| term_out | output | WIDTH | Current term (sum register) |

## Verification
The bench builds the block with its defaults: WIDTH = 16 and seeds 0 and 1. At that width the 16-bit wrap is reached after 24 terms, so a run of 30 terms checks both the exact sequence and the modular wrap. A sweep drives all 16 combinations of the three strobes and the select several times, from varied register contents. The held values show up at the output through later sum captures, and a reset asserted together with every strobe checks that reset wins.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic {
    SRC_SEED = 1'b0,
    SRC_FEED = 1'b1
  } src_e;

  localparam int unsigned NUM_REGS  = 3;
  localparam int unsigned NUM_TERMS = 2;

endpackage

// File: rtl/fib_ld_reg.sv
module fib_ld_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> q == '0)
    else $error("reset did not clear register");

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ld |=> q == $past(q))
    else $error("register changed without load");

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(d))
    else $error("register missed its load");

endmodule

// File: rtl/fib_src_mux.sv
module fib_src_mux
  import fib_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  src_e             sel,
  input  logic [WIDTH-1:0] seed,
  input  logic [WIDTH-1:0] feed,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (sel)
      SRC_FEED: y = feed;
      default:  y = seed;
    endcase
  end

endmodule

// File: rtl/fib_gen.sv
module fib_gen
  import fib_pkg::*;
#(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned SEED_OLD = 0,
  parameter int unsigned SEED_NEW = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_old,
  input  logic             ld_new,
  input  logic             ld_sum,
  input  logic             sel_run,
  output logic [WIDTH-1:0] term_out
);

  localparam logic [WIDTH-1:0] SEED_OLD_V = WIDTH'(SEED_OLD);
  localparam logic [WIDTH-1:0] SEED_NEW_V = WIDTH'(SEED_NEW);

  // index 0: older term, 1: newer term, 2: sum
  logic [WIDTH-1:0]    q_r [NUM_REGS];
  logic [WIDTH-1:0]    d_c [NUM_REGS];
  logic [NUM_REGS-1:0] ld_v;
  logic [WIDTH-1:0]    sum_c;
  src_e                src;

  assign ld_v  = {ld_sum, ld_new, ld_old};
  assign src   = src_e'(sel_run);
  assign sum_c = q_r[0] + q_r[1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < NUM_TERMS) begin : g_term
      // each term register moves one place along from its successor
      fib_src_mux #(.WIDTH(WIDTH)) u_mux (
        .sel  (src),
        .seed ((i == 0) ? SEED_OLD_V : SEED_NEW_V),
        .feed (q_r[i+1]),
        .y    (d_c[i])
      );
    end else begin : g_sum
      assign d_c[i] = sum_c;
    end

    fib_ld_reg #(.WIDTH(WIDTH)) u_reg (
      .clk (clk),
      .rst (rst),
      .ld  (ld_v[i]),
      .d   (d_c[i]),
      .q   (q_r[i])
    );
  end

  assign term_out = q_r[NUM_REGS-1];

  p_seed_old_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_run && ld_old) |=> q_r[0] == SEED_OLD_V)
    else $error("older seed not loaded");

  p_seed_new_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_run && ld_new) |=> q_r[1] == SEED_NEW_V)
    else $error("newer seed not loaded");

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_run && ld_old && ld_new) |=> (q_r[0] == $past(q_r[1])) && (q_r[1] == $past(term_out)))
    else $error("feedback shift wrong");

  p_sum_r5: assert property (@(posedge clk) disable iff (rst)
    ld_sum |=> term_out == $past(q_r[0]) + $past(q_r[1]))
    else $error("sum register wrong");

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_sum |=> $stable(term_out))
    else $error("output moved without sum load");

endmodule

// File: tb/fib_gen_bench.sv
module fib_gen_bench;

  localparam int unsigned W      = 16;
  localparam time         CLK_T  = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_old = 1'b0, ld_new = 1'b0, ld_sum = 1'b0, sel_run = 1'b0;
  logic [W-1:0] term_out;

  int n_cmp = 0;
  int n_bad = 0;

  // model of the three registers, from the requirements
  logic [W-1:0] m_old = '0, m_new = '0, m_sum = '0;

  always #(CLK_T/2) clk = ~clk;

  fib_gen u_fib_gen (
    .clk(clk), .rst(rst), .ld_old(ld_old), .ld_new(ld_new),
    .ld_sum(ld_sum), .sel_run(sel_run), .term_out(term_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: term_out=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one clock with given controls; model follows R2..R6
  task automatic step(input logic e_old, input logic e_new, input logic e_sum,
                      input logic run, input string tag);
    logic [W-1:0] n_old, n_new, n_sum;
    @(negedge clk);
    ld_old = e_old; ld_new = e_new; ld_sum = e_sum; sel_run = run;
    n_old = e_old ? (run ? m_new : W'(0)) : m_old;
    n_new = e_new ? (run ? m_sum : W'(1)) : m_new;
    n_sum = e_sum ? W'(m_old + m_new) : m_sum;
    @(posedge clk);
    #1;
    m_old = n_old; m_new = n_new; m_sum = n_sum;
    check(tag, term_out, m_sum);
  endtask

  task automatic do_reset(input logic strobes);
    @(negedge clk);
    rst = 1'b1;
    ld_old = strobes; ld_new = strobes; ld_sum = strobes; sel_run = strobes;
    @(posedge clk);
    #1;
    m_old = '0; m_new = '0; m_sum = '0;
    check("R1 reset", term_out, '0);
    @(negedge clk);
    rst = 1'b0;
    ld_old = 0; ld_new = 0; ld_sum = 0; sel_run = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    logic [W-1:0] fa, fb, fc;
    repeat (2) @(posedge clk);
    do_reset(1'b0);
    check("R7 idle output", term_out, '0);

    // seed, then first sum must be seed_old + seed_new = 1 (R2, R3)
    step(1, 1, 0, 0, "R2 seed load holds output");
    step(0, 0, 1, 0, "R3 first sum");
    check("R3 first sum value", term_out, W'(1));

    // Fibonacci run with wrap (R8, R4, R5)
    fa = '0; fb = W'(1);
    for (int k = 2; k <= 30; k++) begin
      if (k > 2) step(0, 0, 1, 1, "R5 sum capture");
      fc = fa + fb;
      check("R8 fibonacci term", term_out, fc);
      if (k == 24) check("R8 F24", term_out, W'(46368));
      if (k == 25) check("R8 F25 wraps", term_out, W'(75025 % 65536));
      fa = fb; fb = fc;
      step(1, 1, 0, 1, "R4 shift keeps output");
    end

    // output holds while sum strobe low (R6, R7)
    for (int j = 0; j < 4; j++) step(j[0], j[1], 0, j[0] ^ j[1], "R6 output hold");

    // near-exhaustive strobe/select sweep from varied states (R6)
    for (int rep = 0; rep < 6; rep++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [3:0] c;
        c = 4'(idx ^ (rep * 5));
        step(c[3], c[2], c[1], c[0], "R6 sweep");
        step(0, 0, 1, 1, "R6 sweep sum probe");
      end
    end

    // reset wins over all strobes, and clears term registers (R1)
    step(1, 1, 1, 1, "R6 pre-reset");
    do_reset(1'b1);
    step(0, 0, 1, 1, "R1 cleared terms sum");
    check("R1 cleared terms zero", term_out, '0);

    // seed only newer term, older stays 0 -> sum 1 (R3, R6)
    step(0, 1, 0, 0, "R3 newer seed only");
    step(0, 0, 1, 1, "R3 sum after newer seed");
    check("R3 newer seed value", term_out, W'(1));

    finish_run();
  end

endmodule